// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire serial bus (I2C, Standard and Fast mode up to 400 kbit/s). It lets a bus master read and write a bank of sixteen byte-wide registers that live outside the block. The register bank is reached through a simple register-bus port. A write strobe carries the register select and the data byte. A read strobe fetches a byte that the bank must return combinationally in the same clock cycle.

The 7-bit device address is made of three fixed upper bits, set by a parameter, and four low bits taken from external strap pins. That gives sixteen selectable addresses. After the device address, the master sends a register-address byte. Only bits 6:3 of that byte select the register. Bits 2:1 must be zero, and bits 7 and 0 carry no meaning.

After each data byte the register select steps forward by one, and it wraps from 15 back to 0. To read, the master writes the register-address byte, issues a repeated START, and then sends the device address with the read bit set.

Both SCL and SDA pass through a synchroniser and a persistence filter before any edge is detected. The block only pulls SDA low, through an open-drain enable. It never stretches the clock, and it recognises neither 10-bit addresses nor general call.

The controller is a single state machine with these states and transitions:
- IDLE: waits for a START.
- DEV_ADDR: shifts in the address byte. After the eighth bit it moves to DEV_ACK if the address matches, and to IGNORE if it does not.
- DEV_ACK: on a write it moves to REG_ADDR. On a read it moves to RD_DATA and fetches the first byte.
- REG_ADDR: moves to REG_ACK if bits 2:1 are zero, and to IGNORE otherwise.
- REG_ACK: moves to WR_DATA.
- WR_DATA: moves to WR_ACK after eight bits and strobes the write.
- WR_ACK: returns to WR_DATA.
- RD_DATA: moves to RD_ACK after eight bits.
- RD_ACK: moves to IGNORE on a master NACK. On an ACK it returns to RD_DATA and fetches the next byte.
- IGNORE: waits for the next START or STOP.

A START from any state moves to DEV_ADDR. A STOP from any state moves to IDLE.

Top module: `i2c_reg_slave`

## Requirements
- R1: A device-address byte whose upper seven bits equal {DEV_ADDR_HI, addr_strap} is acknowledged. The slave pulls SDA low during the ninth clock. Bit 0 of that byte is 0 for write and 1 for read.
- R2: A device-address byte that does not match is not acknowledged. The slave keeps SDA released and produces no register strobes until the next START.
- R3: In the register-address byte, bits 6:3 give the register select, and bits 7 and 0 have no effect.
- R4: A register-address byte with bits 2:1 not equal to 00 is not acknowledged. Later data bytes in that transaction are neither acknowledged nor written.
- R5: Each data byte of a write is acknowledged. It is presented MSB-first-assembled as a one-cycle reg_wr pulse, with reg_addr set to the current select and reg_wdata set to the byte.
- R6: After every written or read byte, the register select increments by one, wrapping from 15 to 0.
- R7: A read after a repeated START shifts out the byte from the current select, MSB first. Each fetch produces one reg_rd pulse with reg_addr set to the select.
- R8: When the master NACKs a read byte, the slave releases SDA and fetches no further bytes.
- R9: A STOP returns the slave to idle. A START, including a repeated START, restarts address reception from any state.
- R10: A pulse on SCL shorter than FILT_LEN clock cycles has no effect on the received bits.
- R11: sda_oe changes only while the filtered SCL is low, except when it is cleared at a START or STOP.
- R12: After reset, sda_oe, reg_wr and reg_rd are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_strap | input | STRAP_W | Low bits of the device address |
| reg_addr | output | RSEL_W | Register select for the register bus |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data byte |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the reg_rd cycle |

## Verification
The bench aims at the register-select wrap from 15 to 0, on both writes and reads. A design that fails to wrap would write or return the wrong registers. It also checks that bits 7 and 0 of the register-address byte are ignored, while non-zero bits 2:1 give a NACK. Decoding the select from the low bits would misplace the writes. Accepting a malformed byte would produce writes that the scoreboard does not expect.

On reads, the bench counts the fetch strobes around the master's final NACK. A design that keeps fetching after the NACK, or keeps driving SDA, is caught there. The bench also checks a foreign device address, a two-cycle SCL glitch inside a byte, and a STOP in the middle of a byte. A design with no filter would gain an extra bit. One that mishandles the abort would lose the transfer that follows.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_REG_ADDR,
        ST_REG_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } i2c_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= 2'b11;
            line_o   <= 1'b1;
            hold_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                hold_cnt <= '0;
            end else if (hold_cnt == CNT_W'(FILT_LEN - 1)) begin
                line_o   <= sync_q[1];
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_rs_pkg::*;
#(
    parameter logic [2:0] DEV_ADDR_HI = 3'b100,
    parameter int         STRAP_W     = 4,
    parameter int         RSEL_W      = 4,
    parameter int         FILT_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [STRAP_W-1:0] addr_strap,
    output logic [RSEL_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int ADDR_W = 3 + STRAP_W;
    localparam int BCNT_W = $clog2(BYTE_W + 1);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W);

    logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
    i2c_state_e state, nxt;
    logic [BYTE_W-1:0] sh;
    logic [BCNT_W-1:0] bit_cnt;
    logic [RSEL_W-1:0] ptr;
    logic rw_q;
    logic [ADDR_W-1:0] dev_addr;
    logic byte_done, addr_hit, ra_ok, shift_state;

    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));
    i2c_bus_events u_evt (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    assign dev_addr    = {DEV_ADDR_HI, addr_strap};
    assign byte_done   = scl_fall && (bit_cnt == LAST_BIT);
    assign addr_hit    = (sh[BYTE_W-1:1] == dev_addr);
    assign ra_ok       = (sh[2:1] == 2'b00);
    assign shift_state = (state == ST_DEV_ADDR) || (state == ST_REG_ADDR) ||
                         (state == ST_WR_DATA)  || (state == ST_RD_DATA);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_IGNORE: nxt = state;
            ST_DEV_ADDR: if (byte_done) nxt = addr_hit ? ST_DEV_ACK : ST_IGNORE;
            ST_DEV_ACK:  if (scl_fall) nxt = rw_q ? ST_RD_DATA : ST_REG_ADDR;
            ST_REG_ADDR: if (byte_done) nxt = ra_ok ? ST_REG_ACK : ST_IGNORE;
            ST_REG_ACK:  if (scl_fall) nxt = ST_WR_DATA;
            ST_WR_DATA:  if (byte_done) nxt = ST_WR_ACK;
            ST_WR_ACK:   if (scl_fall) nxt = ST_WR_DATA;
            ST_RD_DATA:  if (byte_done) nxt = ST_RD_ACK;
            ST_RD_ACK: begin
                if (scl_rise && sda_f) nxt = ST_IGNORE;
                else if (scl_fall)     nxt = ST_RD_DATA;
            end
            default: nxt = ST_IDLE;
        endcase
        if (start_det)     nxt = ST_DEV_ADDR;
        else if (stop_det) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // register-bus strobes
    always_comb begin
        reg_addr  = ptr;
        reg_wdata = sh;
        reg_wr    = (state == ST_WR_DATA) && byte_done;
        reg_rd    = scl_fall && (((state == ST_DEV_ACK) && rw_q) || (state == ST_RD_ACK));
    end

    // datapath and SDA drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            rw_q    <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            if (scl_rise && shift_state && (bit_cnt != LAST_BIT)) begin
                bit_cnt <= bit_cnt + 1'b1;
                if (state != ST_RD_DATA) sh <= {sh[BYTE_W-2:0], sda_f};
            end
            if (scl_fall) begin
                unique case (state)
                    ST_DEV_ADDR: if (byte_done) begin
                        rw_q    <= sh[0];
                        sda_oe  <= addr_hit;
                        bit_cnt <= '0;
                    end
                    ST_DEV_ACK: begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            sh     <= reg_rdata;
                            ptr    <= ptr + 1'b1;
                            sda_oe <= ~reg_rdata[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_REG_ADDR: if (byte_done) begin
                        bit_cnt <= '0;
                        sda_oe  <= ra_ok;
                        if (ra_ok) ptr <= sh[RSEL_W+2:3];
                    end
                    ST_REG_ACK, ST_WR_ACK: begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                    end
                    ST_WR_DATA: if (byte_done) begin
                        ptr     <= ptr + 1'b1;
                        sda_oe  <= 1'b1;
                        bit_cnt <= '0;
                    end
                    ST_RD_DATA: begin
                        if (byte_done) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                        end else begin
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~sh[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        sh      <= reg_rdata;
                        ptr     <= ptr + 1'b1;
                        sda_oe  <= ~reg_rdata[BYTE_W-1];
                        bit_cnt <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && !reg_wr && !reg_rd));
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    // R6
    wr_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_addr == $past(reg_addr) + 1'b1));
    // R6
    rd_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> (reg_addr == $past(reg_addr) + 1'b1));
    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV_ADDR));
    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));
    // R11
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_f);
endmodule

// File: tb/sim_i2c_reg_slave.sv
module sim_i2c_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;
    localparam logic [6:0] MY_ADDR = {3'b100, 4'b0110};

    logic clk = 0;
    logic rst_n = 0;
    logic scl_m = 1, sda_m = 1;
    logic sda_oe, reg_wr, reg_rd;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] mem [16];
    logic [7:0] exp_mem [16];
    logic [11:0] sb_q [$];
    wire sda_line = sda_m & ~sda_oe;
    int checks = 0, errors = 0, rd_cnt = 0, oe_bad = 0;
    logic oe_prev = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_strap(4'b0110), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata));

    assign reg_rdata = mem[reg_addr];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on every write strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    automatic logic [11:0] e = sb_q.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R5/R6 write item", {reg_addr, reg_wdata}, e);
                end
                mem[reg_addr] = reg_wdata;
            end
            if (reg_rd) rd_cnt++;
            if (sda_oe != oe_prev && scl_m) oe_bad++;
            oe_prev = sda_oe;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(Q);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b;
        if (glitch) begin
            wq(Q/2); scl_m = 1; wq(2); scl_m = 0; wq(Q/2 - 2);
        end else begin
            wq(Q);
        end
        scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && (i == 4));
        sda_m = 1; wq(Q); scl_m = 1; wq(Q);
        ack = !sda_line;
        wq(Q); scl_m = 0; wq(Q);
    endtask

    task automatic read_byte(input bit last, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1; wq(Q); scl_m = 1; wq(Q);
            d[i] = sda_line;
            wq(Q); scl_m = 0; wq(Q);
        end
        send_bit(last, 0);
    endtask

    // driver: write n bytes starting at register sel, with raw register byte rb
    task automatic do_write(input logic [7:0] rb, input int n, input logic [7:0] seed, input string tag);
        bit ack;
        logic [3:0] sel = rb[6:3];
        bus_start();
        write_byte({MY_ADDR, 1'b0}, 0, ack);
        chk(ack, {"R1 addr ack ", tag}, ack, 1);
        write_byte(rb, 0, ack);
        chk(ack, {"R3 regbyte ack ", tag}, ack, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d = seed + 8'(k * 13);
            sb_q.push_back({sel, d});
            exp_mem[sel] = d;
            write_byte(d, 0, ack);
            chk(ack, {"R5 data ack ", tag}, ack, 1);
            sel = sel + 1'b1;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [3:0] sel0, input int n, input string tag);
        bit ack;
        logic [7:0] d;
        logic [3:0] sel = sel0;
        rd_cnt = 0;
        bus_start();
        write_byte({MY_ADDR, 1'b0}, 0, ack);
        write_byte({1'b0, sel0, 3'b000}, 0, ack);
        bus_start();
        write_byte({MY_ADDR, 1'b1}, 0, ack);
        chk(ack, {"R1 read addr ack ", tag}, ack, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k == n - 1, d);
            chk(d == exp_mem[sel], {"R7/R6 read data ", tag}, d, exp_mem[sel]);
            sel = sel + 1'b1;
        end
        wq(Q);
        chk(sda_oe == 0, {"R8 released after NACK ", tag}, sda_oe, 0);
        bus_stop();
        chk(rd_cnt == n, {"R8 fetch count ", tag}, rd_cnt, n);
    endtask

    initial begin
        bit ack;
        for (int i = 0; i < 16; i++) begin
            mem[i] = 8'h30 + 8'(i * 7);
            exp_mem[i] = mem[i];
        end
        wq(5);
        chk(!sda_oe && !reg_wr && !reg_rd, "R12 reset outputs", {sda_oe, reg_wr, reg_rd}, 0);
        rst_n = 1;
        wq(20);
        chk(!sda_oe, "R12 idle sda released", sda_oe, 0);

        do_write(8'b0_0101_000, 2, 8'hA5, "two bytes");
        do_write(8'b0_1111_000, 3, 8'h11, "wrap");
        do_write(8'b1_0011_001, 1, 8'hC3, "bits7/0 set");

        // R4: bits 2:1 non-zero
        bus_start();
        write_byte({MY_ADDR, 1'b0}, 0, ack);
        write_byte(8'b0_0101_010, 0, ack);
        chk(!ack, "R4 bad register byte NACK", ack, 0);
        write_byte(8'h77, 0, ack);
        chk(!ack, "R4 data after bad byte NACK", ack, 0);
        bus_stop();

        // R2: foreign address
        rd_cnt = 0;
        bus_start();
        write_byte({MY_ADDR ^ 7'h01, 1'b0}, 0, ack);
        chk(!ack, "R2 foreign address NACK", ack, 0);
        write_byte(8'b0_0010_000, 0, ack);
        chk(!ack, "R2 later byte ignored", ack, 0);
        write_byte(8'h5A, 0, ack);
        bus_stop();
        chk(rd_cnt == 0, "R2 no fetch", rd_cnt, 0);

        do_read(4'd9, 3, "three bytes");
        do_read(4'd15, 2, "wrap");

        // R10: SCL glitch inside a data byte
        bus_start();
        write_byte({MY_ADDR, 1'b0}, 0, ack);
        write_byte(8'b0_0110_000, 0, ack);
        sb_q.push_back({4'd6, 8'h96});
        exp_mem[6] = 8'h96;
        write_byte(8'h96, 1, ack);
        chk(ack, "R10 glitched byte ack", ack, 1);
        bus_stop();

        // R9: STOP mid-byte, then normal transfer
        bus_start();
        write_byte({MY_ADDR, 1'b0}, 0, ack);
        send_bit(0, 0); send_bit(1, 0); send_bit(1, 0);
        bus_stop();
        wq(Q);
        chk(!sda_oe, "R9 idle after stop", sda_oe, 0);
        do_write(8'b0_0001_000, 1, 8'h3C, "after abort");
        do_read(4'd1, 1, "after abort");

        wq(4*Q);
        chk(sb_q.size() == 0, "R5 all expected writes seen", sb_q.size(), 0);
        chk(oe_bad == 0, "R11 sda_oe only changes with SCL low", oe_bad, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule